// File: doc/BRIEF.md
# Burst Command Engine for Local Data Memory

This block sits beside a small word-addressed processor and moves fixed eight-word bursts between the processor's local data memory and an external DRAM controller. The processor programs it with plain output-strobe writes. A two-bit selector picks one of three registers: a command word, a DRAM address and a local start address. Writing the command word starts the burst.

The engine reaches local memory only through a second port of that memory, which the processor never uses, so processor loads and stores run undisturbed during a burst. Toward the controller it raises a request, holds the command and address until the controller acknowledges, and then streams the data. In a write burst, local words are streamed out to the controller. In a read burst, words delivered by the controller are stored into local memory. Software learns that a burst has finished by polling a completion flag through its input path.

Top module: `burst_cmd_engine`

## Requirements
- R1: After reset, `done` is 1, `ctl_req` is 0, no local memory access or write beat is issued, and all three registers are zero.
- R2: A write with `io_wr_stb` high is steered by `io_wr_sel`. Selector 0 loads the command word: bits [2:0] are the operation code, bit [3] is the controller select and bits [5:4] are the rank. Selector 1 loads the 31-bit DRAM address. Selector 2 loads the 10-bit local start address from data bits [9:0]. The command fields appear on `ctl_cmd`, `ctl_csel` and `ctl_rank`, and the DRAM address appears on `ctl_addr`.
- R3: A command write with code 0 (write to DRAM) or code 1 (read from DRAM), made while `done` is 1, clears `done` on the next cycle and raises `ctl_req`. `ctl_req` and `ctl_addr` stay unchanged until the cycle in which `ctl_ack` is seen high.
- R4: For code 0, after the acknowledge the engine reads local words base, base+1, … base+7. It presents them in that order on `ctl_wdata`, with `ctl_wvalid` high on eight consecutive cycles.
- R5: For code 1, after the acknowledge each cycle with `ctl_rvalid` high writes `ctl_rdata` into local word base+n, for n = 0 to 7 in order. Cycles without `ctl_rvalid` are waited out. Local reads and local writes are never issued in the same cycle.
- R6: `done` returns to 1 on the cycle after the eighth beat, which is the eighth write beat for code 0 or the eighth accepted word for code 1.
- R7: A command write with codes 2 to 7 raises no request and makes no memory access, and `done` stays 1.
- R8: A command write made while `done` is 0 is ignored: the running burst keeps its direction, `ctl_cmd` keeps its value, and no extra burst follows.
- R9: Local addresses wrap modulo 1024, so a burst started at 1022 uses words 1022, 1023, 0, 1, … 5.
- R10: A write with selector 3 changes nothing. The address registers keep their values across bursts, so a second command without new address writes uses the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr_stb | input | 1 | Output strobe from the processor |
| io_wr_sel | input | 2 | Register selector, the low bits of the selector operand |
| io_wr_data | input | 31 | Write data operand |
| done | output | 1 | Completion flag, 1 when idle |
| ctl_req | output | 1 | Burst request to the controller |
| ctl_ack | input | 1 | Controller accepts the request |
| ctl_cmd | output | 3 | Operation code |
| ctl_csel | output | 1 | Controller select |
| ctl_rank | output | 2 | Rank field |
| ctl_addr | output | 31 | DRAM address of the burst |
| ctl_wvalid | output | 1 | Write beat valid |
| ctl_wdata | output | 36 | Write beat data |
| ctl_rvalid | input | 1 | Read word valid from the controller |
| ctl_rdata | input | 36 | Read word data |
| lm_addr | output | 10 | Local memory spare-port address |
| lm_re | output | 1 | Local read enable, with data returned one cycle later |
| lm_rdata | input | 36 | Local read data |
| lm_we | output | 1 | Local write enable |
| lm_wdata | output | 36 | Local write data |

## Verification
The hardest state to reach is a command write that arrives while a burst is still pending. The stimulus issues a read-direction command during the request phase, before any acknowledge. It then shows that the running write burst still delivers its eight beats, that no local write occurs and that no second request follows. Wrap-around is driven by starting both directions near the top of local memory. Read bursts are fed with idle gaps between words, so that the beat counting is exercised apart from the cycle count.

// File: rtl/bce_pkg.sv
`timescale 1ns/1ps
package bce_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_PUSH = 2'd2,
        SQ_PULL = 2'd3
    } sq_state_e;

    localparam logic [2:0] OPC_PUSH = 3'd0;
    localparam logic [2:0] OPC_PULL = 3'd1;

    localparam logic [1:0] RSEL_CMD   = 2'd0;
    localparam logic [1:0] RSEL_DADDR = 2'd1;
    localparam logic [1:0] RSEL_LADDR = 2'd2;

    // packed order puts rank at [5:4], select at [3], code at [2:0]
    typedef struct packed {
        logic [1:0] rank;
        logic       csel;
        logic [2:0] code;
    } cmd_fields_t;

endpackage

// File: rtl/bce_regs.sv
`timescale 1ns/1ps
module bce_regs
    import bce_pkg::*;
#(
    parameter int DAW = 31,
    parameter int LAW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [1:0]      wr_sel,
    input  logic [DAW-1:0]  wr_data,
    input  logic            idle,
    output cmd_fields_t     cmd,
    output logic [DAW-1:0]  daddr,
    output logic [LAW-1:0]  laddr,
    output logic            start,
    output logic [2:0]      start_code
);

    typedef struct packed {
        cmd_fields_t     cmd;
        logic [DAW-1:0]  daddr;
        logic [LAW-1:0]  laddr;
    } regs_t;

    regs_t r_q, r_d;
    logic  hit_cmd;

    always_comb begin
        r_d     = r_q;
        hit_cmd = wr_stb && (wr_sel == RSEL_CMD) && idle;
        if (hit_cmd) begin
            r_d.cmd = cmd_fields_t'(wr_data[5:0]);
        end
        if (wr_stb && (wr_sel == RSEL_DADDR)) begin
            r_d.daddr = wr_data;
        end
        if (wr_stb && (wr_sel == RSEL_LADDR)) begin
            r_d.laddr = wr_data[LAW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd        = r_q.cmd;
    assign daddr      = r_q.daddr;
    assign laddr      = r_q.laddr;
    assign start      = hit_cmd;
    assign start_code = wr_data[2:0];

endmodule

// File: rtl/bce_seq.sv
`timescale 1ns/1ps
module bce_seq
    import bce_pkg::*;
#(
    parameter int DAW   = 31,
    parameter int LAW   = 10,
    parameter int BEATS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      start_code,
    input  logic [DAW-1:0]  daddr,
    input  logic [LAW-1:0]  laddr,
    input  logic            ack,
    input  logic            push_beat,
    input  logic            pull_beat,
    output logic            done,
    output logic            req,
    output logic            issue_en,
    output logic            pull_en,
    output logic [LAW-1:0]  base,
    output logic [LAW-1:0]  offset,
    output logic [DAW-1:0]  xaddr
);

    localparam int            CW   = $clog2(BEATS + 1);
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);
    localparam logic [CW-1:0] FULL = CW'(BEATS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        sq_state_e       st;
        logic            done;
        logic            pull;
        logic [CW-1:0]   iss;
        logic [CW-1:0]   beat;
        logic [LAW-1:0]  base;
        logic [DAW-1:0]  xaddr;
    } seq_t;

    seq_t s_q, s_d;
    logic issue_now;
    logic beat_now;

    always_comb begin
        s_d       = s_q;
        issue_now = (s_q.st == SQ_PUSH) && (s_q.iss != FULL);
        beat_now  = ((s_q.st == SQ_PUSH) && push_beat) ||
                    ((s_q.st == SQ_PULL) && pull_beat);
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start && ((start_code == OPC_PUSH) || (start_code == OPC_PULL))) begin
                    s_d.st    = SQ_REQ;
                    s_d.done  = 1'b0;
                    s_d.pull  = (start_code == OPC_PULL);
                    s_d.iss   = '0;
                    s_d.beat  = '0;
                    s_d.base  = laddr;
                    s_d.xaddr = daddr;
                end
            end
            SQ_REQ: begin
                if (ack) begin
                    s_d.st = s_q.pull ? SQ_PULL : SQ_PUSH;
                end
            end
            default: begin
                if (issue_now) begin
                    s_d.iss = s_q.iss + ONE;
                end
                if (beat_now) begin
                    if (s_q.beat == LAST) begin
                        s_d.st   = SQ_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.beat = s_q.beat + ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= SQ_IDLE;
            s_q.done  <= 1'b1;
            s_q.pull  <= 1'b0;
            s_q.iss   <= '0;
            s_q.beat  <= '0;
            s_q.base  <= '0;
            s_q.xaddr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign req      = (s_q.st == SQ_REQ);
    assign issue_en = issue_now;
    assign pull_en  = (s_q.st == SQ_PULL);
    assign base     = s_q.base;
    assign offset   = (s_q.st == SQ_PUSH) ? LAW'(s_q.iss) : LAW'(s_q.beat);
    assign xaddr    = s_q.xaddr;

endmodule

// File: rtl/bce_lport.sv
`timescale 1ns/1ps
module bce_lport #(
    parameter int DW  = 36,
    parameter int LAW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_en,
    input  logic            pull_en,
    input  logic [LAW-1:0]  base,
    input  logic [LAW-1:0]  offset,
    input  logic [DW-1:0]   lm_rdata,
    input  logic [DW-1:0]   ctl_rdata,
    input  logic            ctl_rvalid,
    output logic [LAW-1:0]  lm_addr,
    output logic            lm_re,
    output logic            lm_we,
    output logic [DW-1:0]   lm_wdata,
    output logic [DW-1:0]   ctl_wdata,
    output logic            ctl_wvalid,
    output logic            push_beat,
    output logic            pull_beat
);

    typedef struct packed {
        logic fly;
    } lp_t;

    lp_t p_q, p_d;

    always_comb begin
        p_d.fly = issue_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // modulo-2^LAW addition gives the wrap at the top of local memory
    assign lm_addr    = base + offset;
    assign lm_re      = issue_en;
    assign lm_we      = pull_en && ctl_rvalid;
    assign lm_wdata   = ctl_rdata;
    assign ctl_wvalid = p_q.fly;
    assign ctl_wdata  = lm_rdata;
    assign push_beat  = p_q.fly;
    assign pull_beat  = lm_we;

endmodule

// File: rtl/burst_cmd_engine.sv
`timescale 1ns/1ps
module burst_cmd_engine
    import bce_pkg::*;
#(
    parameter int DW    = 36,
    parameter int DAW   = 31,
    parameter int LAW   = 10,
    parameter int BEATS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_wr_stb,
    input  logic [1:0]      io_wr_sel,
    input  logic [DAW-1:0]  io_wr_data,
    output logic            done,
    output logic            ctl_req,
    input  logic            ctl_ack,
    output logic [2:0]      ctl_cmd,
    output logic            ctl_csel,
    output logic [1:0]      ctl_rank,
    output logic [DAW-1:0]  ctl_addr,
    output logic            ctl_wvalid,
    output logic [DW-1:0]   ctl_wdata,
    input  logic            ctl_rvalid,
    input  logic [DW-1:0]   ctl_rdata,
    output logic [LAW-1:0]  lm_addr,
    output logic            lm_re,
    input  logic [DW-1:0]   lm_rdata,
    output logic            lm_we,
    output logic [DW-1:0]   lm_wdata
);

    cmd_fields_t     cmd_w;
    logic [DAW-1:0]  daddr_w;
    logic [LAW-1:0]  laddr_w;
    logic            start_w;
    logic [2:0]      code_w;
    logic            done_w;
    logic            issue_w;
    logic            pull_w;
    logic [LAW-1:0]  base_w;
    logic [LAW-1:0]  off_w;
    logic            push_beat_w;
    logic            pull_beat_w;

    bce_regs #(.DAW(DAW), .LAW(LAW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (io_wr_stb),
        .wr_sel     (io_wr_sel),
        .wr_data    (io_wr_data),
        .idle       (done_w),
        .cmd        (cmd_w),
        .daddr      (daddr_w),
        .laddr      (laddr_w),
        .start      (start_w),
        .start_code (code_w)
    );

    bce_seq #(.DAW(DAW), .LAW(LAW), .BEATS(BEATS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_code (code_w),
        .daddr      (daddr_w),
        .laddr      (laddr_w),
        .ack        (ctl_ack),
        .push_beat  (push_beat_w),
        .pull_beat  (pull_beat_w),
        .done       (done_w),
        .req        (ctl_req),
        .issue_en   (issue_w),
        .pull_en    (pull_w),
        .base       (base_w),
        .offset     (off_w),
        .xaddr      (ctl_addr)
    );

    bce_lport #(.DW(DW), .LAW(LAW)) u_lport (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en   (issue_w),
        .pull_en    (pull_w),
        .base       (base_w),
        .offset     (off_w),
        .lm_rdata   (lm_rdata),
        .ctl_rdata  (ctl_rdata),
        .ctl_rvalid (ctl_rvalid),
        .lm_addr    (lm_addr),
        .lm_re      (lm_re),
        .lm_we      (lm_we),
        .lm_wdata   (lm_wdata),
        .ctl_wdata  (ctl_wdata),
        .ctl_wvalid (ctl_wvalid),
        .push_beat  (push_beat_w),
        .pull_beat  (pull_beat_w)
    );

    assign done     = done_w;
    assign ctl_cmd  = cmd_w.code;
    assign ctl_csel = cmd_w.csel;
    assign ctl_rank = cmd_w.rank;

endmodule

// File: rtl/burst_cmd_engine_chk.sv
`timescale 1ns/1ps
module burst_cmd_engine_chk #(
    parameter int DAW = 31,
    parameter int LAW = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            io_wr_stb,
    input logic [1:0]      io_wr_sel,
    input logic [2:0]      wr_code,
    input logic            done,
    input logic            ctl_req,
    input logic            ctl_ack,
    input logic [2:0]      ctl_cmd,
    input logic [DAW-1:0]  ctl_addr,
    input logic            ctl_wvalid,
    input logic [LAW-1:0]  lm_addr,
    input logic            lm_re,
    input logic            lm_we
);

    logic cmd_hit;
    assign cmd_hit = io_wr_stb && (io_wr_sel == 2'd0);

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && done && (wr_code < 3'd2)) |=> (!done && ctl_req)); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && !ctl_ack) |=> ctl_req); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(!done)) |-> $stable(ctl_addr)); // R3

    AST_OTHER_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && done && (wr_code >= 3'd2)) |=> (done && !ctl_req)); // R7

    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !done) |=> $stable(ctl_cmd)); // R8

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(lm_re || lm_we || ctl_wvalid)); // R1

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_re && $past(lm_re)) |-> (lm_addr == $past(lm_addr) + 1'b1)); // R9

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lm_re && lm_we)); // R5

endmodule

bind burst_cmd_engine burst_cmd_engine_chk #(.DAW(DAW), .LAW(LAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr_stb  (io_wr_stb),
    .io_wr_sel  (io_wr_sel),
    .wr_code    (io_wr_data[2:0]),
    .done       (done),
    .ctl_req    (ctl_req),
    .ctl_ack    (ctl_ack),
    .ctl_cmd    (ctl_cmd),
    .ctl_addr   (ctl_addr),
    .ctl_wvalid (ctl_wvalid),
    .lm_addr    (lm_addr),
    .lm_re      (lm_re),
    .lm_we      (lm_we)
);

// File: tb/burst_cmd_engine_test.sv
`timescale 1ns/1ps
module burst_cmd_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_stb = 1'b0;
    logic [1:0]  io_wr_sel = '0;
    logic [30:0] io_wr_data = '0;
    logic        done;
    logic        ctl_req;
    logic        ctl_ack = 1'b0;
    logic [2:0]  ctl_cmd;
    logic        ctl_csel;
    logic [1:0]  ctl_rank;
    logic [30:0] ctl_addr;
    logic        ctl_wvalid;
    logic [35:0] ctl_wdata;
    logic        ctl_rvalid = 1'b0;
    logic [35:0] ctl_rdata = '0;
    logic [9:0]  lm_addr;
    logic        lm_re;
    logic [35:0] lm_rdata;
    logic        lm_we;
    logic [35:0] lm_wdata;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    burst_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .io_wr_stb(io_wr_stb), .io_wr_sel(io_wr_sel),
        .io_wr_data(io_wr_data), .done(done), .ctl_req(ctl_req), .ctl_ack(ctl_ack),
        .ctl_cmd(ctl_cmd), .ctl_csel(ctl_csel), .ctl_rank(ctl_rank), .ctl_addr(ctl_addr),
        .ctl_wvalid(ctl_wvalid), .ctl_wdata(ctl_wdata), .ctl_rvalid(ctl_rvalid),
        .ctl_rdata(ctl_rdata), .lm_addr(lm_addr), .lm_re(lm_re), .lm_rdata(lm_rdata),
        .lm_we(lm_we), .lm_wdata(lm_wdata)
    );

    // local data memory model, one-cycle read latency on the spare port
    logic [35:0] mem [0:1023];
    logic [35:0] rd_q = '0;
    assign lm_rdata = rd_q;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = {26'(i * 37 + 5), 10'(i)};
    end

    always @(posedge clk) begin
        if (lm_we) mem[lm_addr] <= lm_wdata;
        if (lm_re) rd_q <= mem[lm_addr];
    end

    task automatic expect_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [30:0] data);
        @(negedge clk);
        io_wr_stb  = 1'b1;
        io_wr_sel  = sel;
        io_wr_data = data;
        @(negedge clk);
        io_wr_stb  = 1'b0;
    endtask

    task automatic t_reset();
        expect_eq("R1 done after reset", done, 1);
        expect_eq("R1 req after reset", ctl_req, 0);
        expect_eq("R1 no local access", {lm_re, lm_we, ctl_wvalid}, 0);
        expect_eq("R1 registers zero", {ctl_cmd, ctl_csel, ctl_rank, ctl_addr}, 0);
    endtask

    // write burst: local -> DRAM
    task automatic t_push(input logic [9:0] base, input logic [30:0] xa, input logic [5:0] cmdw,
                          input int ack_wait, input bit inject, input bit set_addr);
        int n = 0;
        int first = -1;
        int last = -1;
        bit we_seen = 0;
        if (set_addr) begin
            wr_reg(2'd1, xa);
            wr_reg(2'd2, 31'(base));
        end
        wr_reg(2'd0, 31'(cmdw));
        expect_eq("R3 done cleared", done, 0);
        expect_eq("R3 request raised", ctl_req, 1);
        expect_eq("R2 dram address", ctl_addr, xa);
        expect_eq("R2 command fields", {ctl_rank, ctl_csel, ctl_cmd}, cmdw);
        if (inject) begin
            wr_reg(2'd0, 31'h1);
            expect_eq("R8 cmd kept while busy", ctl_cmd, cmdw[2:0]);
            expect_eq("R8 done stays clear", done, 0);
        end
        repeat (ack_wait) @(negedge clk);
        expect_eq("R3 request held", ctl_req, 1);
        expect_eq("R3 address held", ctl_addr, xa);
        ctl_ack = 1'b1;
        @(negedge clk);
        ctl_ack = 1'b0;
        expect_eq("R3 request dropped after ack", ctl_req, 0);
        for (int c = 0; c < 24 && n < 8; c++) begin
            @(negedge clk);
            if (lm_we) we_seen = 1;
            if (ctl_wvalid) begin
                logic [9:0] a;
                a = base + 10'(n);
                expect_eq("R4 R9 write beat data", ctl_wdata, mem[a]);
                expect_eq("R6 done low during beats", done, 0);
                if (first < 0) first = c;
                last = c;
                n++;
            end
        end
        expect_eq("R4 beat count", n, 8);
        expect_eq("R4 beats consecutive", last - first, 7);
        expect_eq("R8 no local write in write burst", we_seen, 0);
        @(negedge clk);
        expect_eq("R6 done after last beat", done, 1);
        expect_eq("R4 no extra beat", ctl_wvalid, 0);
        repeat (3) begin
            @(negedge clk);
            expect_eq("R8 no follow-on request", ctl_req, 0);
        end
    endtask

    // read burst: DRAM -> local, with optional idle gaps
    task automatic t_pull(input logic [9:0] base, input logic [30:0] xa, input logic [5:0] cmdw,
                          input bit gaps);
        wr_reg(2'd1, xa);
        wr_reg(2'd2, 31'(base));
        wr_reg(2'd0, 31'(cmdw));
        expect_eq("R3 done cleared", done, 0);
        expect_eq("R3 request raised", ctl_req, 1);
        expect_eq("R2 command fields", {ctl_rank, ctl_csel, ctl_cmd}, cmdw);
        ctl_ack = 1'b1;
        @(negedge clk);
        ctl_ack = 1'b0;
        for (int n = 0; n < 8; n++) begin
            ctl_rvalid = 1'b1;
            ctl_rdata  = {4'h9, 22'(n * 13), xa[9:0] ^ 10'(n)};
            @(negedge clk);
            ctl_rvalid = 1'b0;
            ctl_rdata  = 36'hBAD_BAD_BAD;
            if (n < 7) expect_eq("R6 done low mid burst", done, 0);
            if (gaps && n < 7) repeat (2) @(negedge clk);
        end
        expect_eq("R6 done after eighth word", done, 1);
        for (int n = 0; n < 8; n++) begin
            logic [9:0] a;
            a = base + 10'(n);
            expect_eq("R5 R9 local word stored", mem[a], {4'h9, 22'(n * 13), xa[9:0] ^ 10'(n)});
        end
        @(negedge clk);
        expect_eq("R5 no write after burst", lm_we, 0);
    endtask

    task automatic t_other_codes();
        for (int k = 2; k < 8; k++) begin
            wr_reg(2'd0, 31'(k));
            repeat (3) begin
                expect_eq("R7 done stays set", done, 1);
                expect_eq("R7 no request or access", {ctl_req, lm_re, lm_we}, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push(10'h010, 31'h1234567, 6'h28, 3, 0, 1);
        t_pull(10'h200, 31'h7FFF0001, 6'h11, 1);
        t_pull(10'h080, 31'h00000ABC, 6'h01, 0);
        t_other_codes();
        t_push(10'h3FC, 31'h0000F00D, 6'h00, 0, 0, 1);   // R9
        t_pull(10'h3FE, 31'h00C0FFEE, 6'h39, 1);         // R9
        t_push(10'h040, 31'h55AA55A, 6'h18, 2, 1, 1);    // R8
        wr_reg(2'd3, 31'h7FFFFFFF);                      // R10
        expect_eq("R10 selector 3 leaves address", ctl_addr, 31'h55AA55A);
        t_push(10'h040, 31'h55AA55A, 6'h28, 1, 0, 0);    // R10
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule